// File: doc/BRIEF.md
# Filtered External Interrupt Conditioner

This block prepares one asynchronous external interrupt pin for use inside a synchronous design. The pin is first brought into the system clock domain by a short flop chain. It can then pass through an optional noise filter. The filter looks at the pin only on a sampling strobe whose rate is chosen by a two-bit select. It adopts a new level only once that level has been seen on three sampling strobes in a row.

The filtered level goes to an edge detector. The detector can react to rising edges, falling edges, or both. Each valid edge sets a sticky request flag that software clears with a one-cycle clear strobe. Each valid edge also produces a one-cycle trigger pulse for other peripherals. An enable input blocks both outputs. Priority and vectoring belong to the interrupt controller that consumes the flag.

Top module: `xint_conditioner`

## Requirements
- R1: The pin passes through a two-flop synchronizer. With the filter bypassed, a pin change driven before clock edge k shows up on `trig_o` and `irq_o` after edge k+2.
- R2: With `fsel_i` = 00, the filter is bypassed and the synchronized pin drives the edge detector directly.
- R3: With `fsel_i` = 01, 10 and 11, the filter samples on every clock, every 8th clock and every 32nd clock respectively. The strobes come from a free-running counter that is cleared by reset. A strobe fires when the counter value modulo the divisor equals the divisor minus one.
- R4: When filtering, the filtered level takes a new value only on a sampling strobe where that sample and the two samples before it all equal the new value. A shorter pulse leaves the request flag unchanged.
- R5: With `both_i` = 0, `rise_sel_i` = 1 selects rising edges and `rise_sel_i` = 0 selects falling edges of the filtered level.
- R6: With `both_i` = 1, any change of the filtered level is a valid edge, whatever the value of `rise_sel_i`.
- R7: A valid edge sets `irq_o` to 1. It stays 1 until a clock edge at which `clr_i` is 1 and no new valid edge occurs.
- R8: If a clear and a valid edge happen in the same cycle, `irq_o` ends up set.
- R9: While `en_i` = 0, no edge sets `irq_o` and `trig_o` stays 0. Raising `en_i` while the pin rests at a level does not create an edge.
- R10: `trig_o` is high for exactly the cycle after each valid edge, the same cycle in which `irq_o` becomes set.
- R11: During reset the filtered level and the edge history load the synchronized pin value, and both outputs are 0. Releasing reset with the pin held high produces no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_n_i | input | 1 | Synchronous reset, active low |
| pin_i | input | 1 | Asynchronous external interrupt pin |
| en_i | input | 1 | Enables the request flag and the trigger |
| fsel_i | input | 2 | Filter select: 00 bypass, 01/10/11 sampling every 1/8/32 clocks |
| rise_sel_i | input | 1 | Edge polarity: 1 rising, 0 falling |
| both_i | input | 1 | Detect both edges, overrides polarity |
| clr_i | input | 1 | Clears the request flag for one cycle |
| irq_o | output | 1 | Sticky interrupt request flag |
| trig_o | output | 1 | One-cycle peripheral trigger pulse |

## Verification
The bench builds the block with its default parameters: sampling divisors of 8 and 32, a match count of three and a two-stage synchronizer. With these values every strobe rate can be reached in a few hundred cycles. Pulses of two samples can be placed against accepted pulses of three or more at each rate. The same-cycle clear and edge collision and the reset release with the pin held high are also driven on purpose. A behavioural model tracks the pin history, the strobe counter and the sticky flag, and both outputs are compared against it on every clock.

// File: rtl/xint_pkg.sv
package xint_pkg;

  typedef enum logic [1:0] {
    FSEL_BYPASS = 2'b00,
    FSEL_FAST   = 2'b01,
    FSEL_MID    = 2'b10,
    FSEL_SLOW   = 2'b11
  } fsel_e;

  // strobe when the free-running count reaches the last slot of a period
  function automatic logic strobe_hit(input logic [31:0] cnt, input int unsigned div);
    return (cnt % div) == (div - 1);
  endfunction

  // edge qualification on the conditioned level
  function automatic logic edge_hit(input logic prev, input logic cur,
                                    input logic rise_sel, input logic both);
    logic rise;
    logic fall;
    rise = cur & ~prev;
    fall = prev & ~cur;
    if (both) return rise | fall;
    return rise_sel ? rise : fall;
  endfunction

endpackage

// File: rtl/xint_sync.sv
module xint_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  // deliberately not reset: the chain settles while reset is held
  always_ff @(posedge clk_i) begin
    chain_q <= {chain_q[STAGES-2:0], async_i};
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/xint_strobe_gen.sv
module xint_strobe_gen
  import xint_pkg::*;
#(
  parameter int DIV_MID  = 8,
  parameter int DIV_SLOW = 32
) (
  input  logic       clk_i,
  input  logic       rst_n_i,
  input  logic [1:0] fsel_i,
  output logic       strobe_o
);
  localparam int CW = (DIV_SLOW > 1) ? $clog2(DIV_SLOW) : 1;

  logic [CW-1:0] cnt_q;
  logic          hit_mid;
  logic          hit_slow;

  always_ff @(posedge clk_i) begin
    if (!rst_n_i) cnt_q <= '0;
    else          cnt_q <= cnt_q + 1'b1;
  end

  assign hit_mid  = strobe_hit(32'(cnt_q), DIV_MID);
  assign hit_slow = strobe_hit(32'(cnt_q), DIV_SLOW);

  always_comb begin
    unique case (fsel_e'(fsel_i))
      FSEL_FAST: strobe_o = 1'b1;
      FSEL_MID:  strobe_o = hit_mid;
      FSEL_SLOW: strobe_o = hit_slow;
      default:   strobe_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/xint_glitch_filter.sv
module xint_glitch_filter #(
  parameter int MATCH_COUNT = 3
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic sync_i,
  input  logic bypass_i,
  input  logic strobe_i,
  output logic filt_q_o,
  output logic level_o
);
  localparam int HW = MATCH_COUNT - 1;

  logic [HW-1:0]          hist_q;
  logic                   filt_q;
  logic [MATCH_COUNT-1:0] window;
  logic                   accept;

  assign window = {hist_q, sync_i};
  assign accept = (&window) | ~(|window);

  always_ff @(posedge clk_i) begin
    if (!rst_n_i || bypass_i) begin
      hist_q <= {HW{sync_i}};
      filt_q <= sync_i;
    end else if (strobe_i) begin
      hist_q <= window[HW-1:0];
      if (accept) filt_q <= sync_i;
    end
  end

  assign filt_q_o = filt_q;
  assign level_o  = bypass_i ? sync_i : filt_q;
endmodule

// File: rtl/xint_edge_flag.sv
module xint_edge_flag
  import xint_pkg::*;
(
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic level_i,
  input  logic en_i,
  input  logic rise_sel_i,
  input  logic both_i,
  input  logic clr_i,
  output logic edge_o,
  output logic trig_o,
  output logic irq_o
);
  logic prev_q;
  logic trig_q;
  logic flag_q;

  assign edge_o = en_i & edge_hit(prev_q, level_i, rise_sel_i, both_i);

  always_ff @(posedge clk_i) begin
    prev_q <= level_i;
    if (!rst_n_i) begin
      trig_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      trig_q <= edge_o;
      flag_q <= edge_o | (flag_q & ~clr_i);
    end
  end

  assign trig_o = trig_q;
  assign irq_o  = flag_q;
endmodule

// File: rtl/xint_conditioner.sv
module xint_conditioner #(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_MID     = 8,
  parameter int DIV_SLOW    = 32,
  parameter int MATCH_COUNT = 3
) (
  input  logic       clk_i,
  input  logic       rst_n_i,
  input  logic       pin_i,
  input  logic       en_i,
  input  logic [1:0] fsel_i,
  input  logic       rise_sel_i,
  input  logic       both_i,
  input  logic       clr_i,
  output logic       irq_o,
  output logic       trig_o
);
  logic sync_w;
  logic strobe_w;
  logic filt_w;
  logic level_w;
  logic edge_w;
  logic bypass_w;

  assign bypass_w = (fsel_i == 2'b00);

  xint_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .async_i (pin_i),
    .sync_o  (sync_w)
  );

  xint_strobe_gen #(.DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)) u_strobe (
    .clk_i    (clk_i),
    .rst_n_i  (rst_n_i),
    .fsel_i   (fsel_i),
    .strobe_o (strobe_w)
  );

  xint_glitch_filter #(.MATCH_COUNT(MATCH_COUNT)) u_filter (
    .clk_i    (clk_i),
    .rst_n_i  (rst_n_i),
    .sync_i   (sync_w),
    .bypass_i (bypass_w),
    .strobe_i (strobe_w),
    .filt_q_o (filt_w),
    .level_o  (level_w)
  );

  xint_edge_flag u_edge (
    .clk_i      (clk_i),
    .rst_n_i    (rst_n_i),
    .level_i    (level_w),
    .en_i       (en_i),
    .rise_sel_i (rise_sel_i),
    .both_i     (both_i),
    .clr_i      (clr_i),
    .edge_o     (edge_w),
    .trig_o     (trig_o),
    .irq_o      (irq_o)
  );
endmodule

// File: rtl/xint_conditioner_chk.sv
module xint_conditioner_chk (
  input logic       clk_i,
  input logic       rst_n_i,
  input logic       en_i,
  input logic [1:0] fsel_i,
  input logic       clr_i,
  input logic       irq_o,
  input logic       trig_o,
  input logic       strobe_w,
  input logic       filt_w,
  input logic       edge_w
);
  // R3: fastest rate samples on every clock
  a_r3_fast_every_cycle: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (fsel_i == 2'b01) |-> strobe_w);

  // R4: filtered level only moves on a strobe
  a_r4_hold_between_strobes: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (fsel_i != 2'b00 && !strobe_w) |=> $stable(filt_w));

  // R7: flag holds while no clear is applied
  a_r7_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (irq_o && !clr_i) |=> irq_o);

  // R8: an edge always leaves the flag set, clear or not
  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    edge_w |=> irq_o);

  // R9: disabled input produces no trigger
  a_r9_enable_gate: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !en_i |=> !trig_o);

  // R10: trigger coincides with a set flag
  a_r10_trig_with_flag: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    trig_o |-> irq_o);

  // R11: outputs quiet right after reset release
  a_r11_reset_quiet: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(rst_n_i) |-> (!irq_o && !trig_o));
endmodule

bind xint_conditioner xint_conditioner_chk u_chk (
  .clk_i    (clk_i),
  .rst_n_i  (rst_n_i),
  .en_i     (en_i),
  .fsel_i   (fsel_i),
  .clr_i    (clr_i),
  .irq_o    (irq_o),
  .trig_o   (trig_o),
  .strobe_w (strobe_w),
  .filt_w   (filt_w),
  .edge_w   (edge_w)
);

// File: tb/xint_conditioner_tb_top.sv
module xint_conditioner_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin = 1'b0;
  logic       en = 1'b0;
  logic [1:0] fsel = 2'b00;
  logic       rise_sel = 1'b1;
  logic       both = 1'b0;
  logic       clr = 1'b0;
  logic       irq;
  logic       trig;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  string phase = "R11";
  int trig_while_off = 0;

  always #5 clk = ~clk;

  xint_conditioner dut_i (
    .clk_i      (clk),
    .rst_n_i    (rst_n),
    .pin_i      (pin),
    .en_i       (en),
    .fsel_i     (fsel),
    .rise_sel_i (rise_sel),
    .both_i     (both),
    .clr_i      (clr),
    .irq_o      (irq),
    .trig_o     (trig)
  );

  // behavioural reference model
  int m_s1 = 0, m_s2 = 0, m_cnt = 0, m_fl = 0, m_pv = 0, m_trg = 0, m_flg = 0;
  int m_samp[$];

  always @(posedge clk) begin
    int lvl, strobe, valid, n_fl;
    int n_pv, n_trg, n_flg, n_cnt;
    lvl = (fsel == 2'b00) ? m_s2 : m_fl;
    strobe = (fsel == 2'b01) ||
             (fsel == 2'b10 && (m_cnt % 8) == 7) ||
             (fsel == 2'b11 && (m_cnt % 32) == 31);
    if (both)          valid = (lvl != m_pv);
    else if (rise_sel) valid = (lvl == 1 && m_pv == 0);
    else               valid = (lvl == 0 && m_pv == 1);
    valid = valid && en;
    n_pv = lvl;
    n_fl = m_fl;
    if (!rst_n || fsel == 2'b00) begin
      n_fl = m_s2;
      m_samp = '{m_s2, m_s2, m_s2};
    end else if (strobe) begin
      m_samp.push_back(m_s2);
      if (m_samp.size() > 3) void'(m_samp.pop_front());
      if (m_samp[0] == m_s2 && m_samp[1] == m_s2 && m_samp[2] == m_s2) n_fl = m_s2;
    end
    if (!rst_n) begin
      n_trg = 0; n_flg = 0; n_cnt = 0;
    end else begin
      n_trg = valid;
      n_flg = (valid || (m_flg && !clr)) ? 1 : 0;
      n_cnt = (m_cnt + 1) % 32;
    end
    m_fl = n_fl; m_pv = n_pv; m_trg = n_trg; m_flg = n_flg; m_cnt = n_cnt;
    m_s2 = m_s1; m_s1 = pin;
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (irq !== m_flg[0] || trig !== m_trg[0]) begin
        fails++;
        $display("FAIL %s model: irq=%0b trig=%0b expected irq=%0d trig=%0d at %0t",
                 phase, irq, trig, m_flg, m_trg, $time);
      end
      if (!en && trig) trig_while_off++;
    end
  end

  task automatic expect_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_flag();
    clr = 1'b1; cyc(1); clr = 1'b0; cyc(1);
  endtask

  initial begin
    cyc(6);
    expect_bit("R11 irq at reset", irq, 1'b0);
    expect_bit("R11 trig at reset", trig, 1'b0);
    rst_n = 1'b1; en = 1'b1;
    cyc(3);

    // bypass, rising
    phase = "R2";
    pin = 1'b1; cyc(6);
    expect_bit("R2 R5 rising sets flag", irq, 1'b1);
    clear_flag(); cyc(2);
    expect_bit("R7 clear drops flag", irq, 1'b0);
    phase = "R5";
    pin = 1'b0; cyc(6);
    expect_bit("R5 falling ignored when rising selected", irq, 1'b0);

    // falling polarity
    rise_sel = 1'b0;
    pin = 1'b1; cyc(6);
    expect_bit("R5 rising ignored when falling selected", irq, 1'b0);
    pin = 1'b0; cyc(6);
    expect_bit("R5 falling sets flag", irq, 1'b1);
    clear_flag();

    // both edges
    phase = "R6"; both = 1'b1; rise_sel = 1'b1;
    pin = 1'b1; cyc(6);
    expect_bit("R6 rise with both", irq, 1'b1);
    clear_flag();
    pin = 1'b0; cyc(6);
    expect_bit("R6 fall with both", irq, 1'b1);
    clear_flag(); both = 1'b0;

    // filter, every clock
    phase = "R4"; fsel = 2'b01; cyc(4);
    pin = 1'b1; cyc(2); pin = 1'b0; cyc(10);
    expect_bit("R4 two-sample glitch rejected", irq, 1'b0);
    pin = 1'b1; cyc(5); pin = 1'b0; cyc(10);
    expect_bit("R4 three-sample pulse accepted", irq, 1'b1);
    clear_flag(); cyc(10);

    // filter, every 8th clock
    phase = "R3"; fsel = 2'b10; cyc(40);
    pin = 1'b1; cyc(12); pin = 1'b0; cyc(40);
    expect_bit("R3 R4 short pulse at div 8 rejected", irq, 1'b0);
    pin = 1'b1; cyc(40);
    expect_bit("R3 long level at div 8 accepted", irq, 1'b1);
    clear_flag(); pin = 1'b0; cyc(40);
    clear_flag();

    // filter, every 32nd clock
    fsel = 2'b11; cyc(120);
    pin = 1'b1; cyc(60); pin = 1'b0; cyc(120);
    expect_bit("R3 R4 short pulse at div 32 rejected", irq, 1'b0);
    pin = 1'b1; cyc(130);
    expect_bit("R3 long level at div 32 accepted", irq, 1'b1);
    clear_flag(); pin = 1'b0; cyc(130);
    clear_flag();

    // enable gating
    phase = "R9"; fsel = 2'b00; both = 1'b1; en = 1'b0; cyc(3);
    for (int i = 0; i < 6; i++) begin
      pin = ~pin; cyc(4);
    end
    pin = 1'b1; cyc(6);
    expect_bit("R9 no flag while disabled", irq, 1'b0);
    expect_bit("R9 no trigger while disabled", (trig_while_off != 0), 1'b0);
    en = 1'b1; cyc(8);
    expect_bit("R9 enabling at rest makes no edge", irq, 1'b0);
    both = 1'b0; pin = 1'b0; cyc(6);

    // R1 latency, R8 collision, R10 pulse width
    phase = "R8"; rise_sel = 1'b1;
    pin = 1'b1; clr = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    expect_bit("R1 nothing after two edges", trig, 1'b0);
    @(negedge clk);
    expect_bit("R8 set wins over clear", irq, 1'b1);
    expect_bit("R10 trigger high with flag", trig, 1'b1);
    @(negedge clk);
    expect_bit("R10 trigger lasts one cycle", trig, 1'b0);
    expect_bit("R7 held clear drops flag", irq, 1'b0);
    clr = 1'b0; cyc(4);

    // reset with pin high
    phase = "R11"; pin = 1'b1; cyc(4);
    rst_n = 1'b0; cyc(6); rst_n = 1'b1; cyc(1);
    expect_bit("R11 quiet after release", trig, 1'b0);
    cyc(10);
    expect_bit("R11 no request from held pin", irq, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule